// File: doc/BRIEF.md
# Multi-bus DAC sample reassembler

This block takes up to four 12-bit sample buses, called A, B, C and D, and rebuilds from them the ordered sample stream for one or two DAC channels. Each bus is double data rate. Its two words per cycle, the rise word and the fall word, arrive already captured in one common clock. A two-bit mode input chooses how the buses are shared out between channels. In mode 0 there are two channels with two buses each. In mode 1 there are two channels with one bus each. In mode 2 one channel uses all four buses.

Each bus also has a strobe. The block uses it to find out how far each active bus is skewed against the others. Buses that arrived early are held back in short delay lines until every bus lines up with the one that arrived last. After that, each channel's output vector holds its samples from earliest to latest. Sample 0 sits in the least significant 12 bits. The rise words come first, in bus letter order, and the fall words follow in the same order.

Top module: `dac_lane_merger`

## Requirements
- R1: While reset is low, out_valid and align_err are 0, and cha_data and chb_data are all zeros.
- R2: Valid needs a strobe on every active bus. Only the first strobe on each bus counts. If the last of these first strobes is sampled at clock edge t, out_valid goes high after edge t+1 and not earlier.
- R3: Mode 0 builds each channel from two buses. cha_data slots 0 to 3 hold A rise, B rise, A fall and B fall. chb_data slots 0 to 3 hold C rise, D rise, C fall and D fall. Slot k is bits [12k+11:12k].
- R4: Mode 1 gives each channel one bus. Bus A feeds channel A: cha_data slot 0 is the A rise word and slot 1 is the A fall word. Bus B feeds channel B: chb_data slot 0 is the B rise word and slot 1 is the B fall word. All higher slots are zero.
- R5: In mode 2, cha_data slots 0 to 7 hold A, B, C and D rise, followed by A, B, C and D fall. chb_data is zero.
- R6: Each active bus is delayed by the number of cycles between its first strobe and the last first strobe, up to 3 cycles. Every output therefore joins words that lie the same number of cycles after their own bus's strobe.
- R7: If that spread is 4 or more cycles, align_err goes high after the lock edge and stays high until reset. While align_err is high, out_valid stays low.
- R8: Once the block is locked, further strobes do not change the per-bus delays.
- R9: Inactive buses play no part. In mode 1 these are buses C and D: their data and strobes neither change the outputs nor hold back lock.
- R10: While out_valid is low, cha_data and chb_data are all zeros.
- R11: If mode changes while reset is high, the edge that sees the change drops out_valid on its next output and clears the alignment. Strobes sampled on that edge are discarded, so alignment starts again from fresh strobes.
- R12: Mode 3 is reserved. In mode 3 no bus is active and out_valid never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the captured word pairs |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Bus-to-channel mapping: 0, 1 or 2; 3 is reserved |
| bus_rise | input | 48 | Rise words; bus A in bits 11:0, then B, C, D |
| bus_fall | input | 48 | Fall words, in the same packing |
| bus_stb | input | 4 | Per-bus strobe, bit 0 = A |
| cha_data | output | 96 | Channel A sample vector, sample 0 in the low slot |
| chb_data | output | 48 | Channel B sample vector |
| out_valid | output | 1 | Channel vectors hold aligned data |
| align_err | output | 1 | Sticky flag: strobe spread was too large |

## Verification
Bus words are random on every cycle, so a swapped bus, a swapped edge or a wrong slot shows up as a data mismatch on the first valid output. Simultaneous strobes test the mapping of each mode on its own. Staggered strobes with spreads of 1 to 3 cycles catch a wrong delay length or a wrong delay direction. A spread of 4 tells the error path apart from the widest legal skew. Strobes sent after lock, strobes and data on inactive buses, and a mode switch with a strobe on the same edge separate a design that really ignores those inputs from one that reacts to them.

// File: rtl/dac_lane_merger.sv
module dac_lane_merger #(
  parameter int W = 12,
  parameter int MAX_SKEW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [4*W-1:0]   bus_rise,
  input  logic [4*W-1:0]   bus_fall,
  input  logic [3:0]       bus_stb,
  output logic [8*W-1:0]   cha_data,
  output logic [4*W-1:0]   chb_data,
  output logic             out_valid,
  output logic             align_err
);
  localparam int AW = $clog2(MAX_SKEW + 2);
  localparam int DW = $clog2(MAX_SKEW + 1);

  logic [1:0]     mode_q;
  logic [3:0]     seen;
  logic           locked;
  logic [AW-1:0]  age  [4];
  logic [DW-1:0]  dly  [4];
  logic [2*W-1:0] hist [4][MAX_SKEW];
  logic [W-1:0]   rs [4];
  logic [W-1:0]   fs [4];
  logic [8*W-1:0] cha_n;
  logic [4*W-1:0] chb_n;
  logic [3:0]     act, seen_n;
  logic           all_in, too_far, vn;

  assign act    = (mode == 2'd1) ? 4'b0011 : (mode == 2'd3) ? 4'b0000 : 4'b1111;
  assign seen_n = seen | (bus_stb & act);
  assign all_in = (act != 4'b0) && ((seen_n & act) == act);
  assign vn     = locked && (mode == mode_q);

  always_comb begin
    too_far = 1'b0;
    for (int b = 0; b < 4; b++) begin
      if (act[b] && seen[b] && age[b] > AW'(MAX_SKEW)) too_far = 1'b1;
    end
  end

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      if (dly[b] == '0) begin
        rs[b] = bus_rise[b*W +: W];
        fs[b] = bus_fall[b*W +: W];
      end else begin
        rs[b] = hist[b][dly[b] - DW'(1)][W-1:0];
        fs[b] = hist[b][dly[b] - DW'(1)][2*W-1:W];
      end
    end
  end

  always_comb begin
    cha_n = '0;
    chb_n = '0;
    case (mode)
      2'd0: begin
        cha_n[4*W-1:0] = {fs[1], fs[0], rs[1], rs[0]};
        chb_n          = {fs[3], fs[2], rs[3], rs[2]};
      end
      2'd1: begin
        cha_n[2*W-1:0] = {fs[0], rs[0]};
        chb_n[2*W-1:0] = {fs[1], rs[1]};
      end
      2'd2: cha_n = {fs[3], fs[2], fs[1], fs[0], rs[3], rs[2], rs[1], rs[0]};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= mode;
      seen      <= '0;
      locked    <= 1'b0;
      align_err <= 1'b0;
      out_valid <= 1'b0;
      cha_data  <= '0;
      chb_data  <= '0;
      for (int b = 0; b < 4; b++) begin
        age[b] <= '0;
        dly[b] <= '0;
        for (int k = 0; k < MAX_SKEW; k++) hist[b][k] <= '0;
      end
    end else begin
      out_valid <= vn;
      cha_data  <= vn ? cha_n : '0;
      chb_data  <= vn ? chb_n : '0;
      for (int b = 0; b < 4; b++) begin
        for (int k = MAX_SKEW - 1; k > 0; k--) hist[b][k] <= hist[b][k-1];
        hist[b][0] <= {bus_fall[b*W +: W], bus_rise[b*W +: W]};
      end
      if (mode != mode_q) begin
        mode_q <= mode;
        seen   <= '0;
        locked <= 1'b0;
        for (int b = 0; b < 4; b++) begin
          age[b] <= '0;
          dly[b] <= '0;
        end
      end else if (!locked && !align_err) begin
        seen <= seen_n;
        for (int b = 0; b < 4; b++) begin
          if (bus_stb[b] && act[b] && !seen[b]) age[b] <= AW'(1);
          else if (seen[b] && age[b] <= AW'(MAX_SKEW)) age[b] <= age[b] + AW'(1);
        end
        if (all_in) begin
          if (too_far) align_err <= 1'b1;
          else begin
            locked <= 1'b1;
            for (int b = 0; b < 4; b++) dly[b] <= seen[b] ? DW'(age[b]) : '0;
          end
        end
      end
    end
  end
endmodule

module dac_merge_chk #(parameter int W = 12) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     mode,
  input logic [8*W-1:0] cha_data,
  input logic [4*W-1:0] chb_data,
  input logic           out_valid,
  input logic           align_err
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (cha_data == '0 && chb_data == '0)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err); // R7
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !out_valid); // R7
  AST_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |=> !out_valid); // R11
  AST_SINGLE_CHB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == 2'd2) |-> chb_data == '0); // R5
  AST_ONE_BUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode) == 2'd1) |-> (cha_data[8*W-1:2*W] == '0 && chb_data[4*W-1:2*W] == '0)); // R4
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd3) |-> !out_valid); // R12
endmodule

bind dac_lane_merger dac_merge_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .cha_data(cha_data),
  .chb_data(chb_data), .out_valid(out_valid), .align_err(align_err)
);

// File: tb/test_dac_lane_merger.sv
`timescale 1ns/1ps
module test_dac_lane_merger;
  localparam int W = 12;
  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     mode = 2'd0;
  logic [4*W-1:0] bus_rise = '0, bus_fall = '0;
  logic [3:0]     bus_stb = '0;
  logic [8*W-1:0] cha_data;
  logic [4*W-1:0] chb_data;
  logic           out_valid, align_err;

  dac_lane_merger i_dac_lane_merger (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bus_rise(bus_rise), .bus_fall(bus_fall),
    .bus_stb(bus_stb), .cha_data(cha_data), .chb_data(chb_data),
    .out_valid(out_valid), .align_err(align_err)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R1";
  bit started = 0;

  int cyc = 0;
  int s_at [4];
  int m_del [4];
  bit m_lock = 0, m_err = 0;
  logic [1:0] m_mode = 2'd0;
  logic [W-1:0] hr [4][4];
  logic [W-1:0] hf [4][4];
  logic [8*W-1:0] e_a = '0;
  logic [4*W-1:0] e_b = '0;
  bit e_v = 0, e_err = 0;

  function automatic logic [W-1:0] wr(int b, int d);
    return (d == 0) ? bus_rise[b*W +: W] : hr[b][d];
  endfunction
  function automatic logic [W-1:0] wf(int b, int d);
    return (d == 0) ? bus_fall[b*W +: W] : hf[b][d];
  endfunction

  always @(posedge clk) begin
    int na, nb, maxd, nact;
    int la [4];
    int lb [4];
    bit actv [4];
    bit allseen;
    started = 1;
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin
        s_at[b] = -1; m_del[b] = 0;
        for (int k = 0; k < 4; k++) begin hr[b][k] = '0; hf[b][k] = '0; end
      end
      m_lock = 0; m_err = 0; m_mode = mode; cyc = 0;
      e_v = 0; e_a = '0; e_b = '0; e_err = 0;
    end else begin
      e_v = m_lock && (mode == m_mode);
      e_a = '0; e_b = '0;
      na = 0; nb = 0;
      la = '{0, 0, 0, 0}; lb = '{0, 0, 0, 0};
      case (mode)
        2'd0: begin na = 2; la = '{0, 1, 0, 0}; nb = 2; lb = '{2, 3, 0, 0}; end
        2'd1: begin na = 1; la = '{0, 0, 0, 0}; nb = 1; lb = '{1, 0, 0, 0}; end
        2'd2: begin na = 4; la = '{0, 1, 2, 3}; end
        default: ;
      endcase
      if (e_v) begin
        for (int i = 0; i < na; i++) begin
          e_a[i*W +: W]      = wr(la[i], m_del[la[i]]);
          e_a[(na+i)*W +: W] = wf(la[i], m_del[la[i]]);
        end
        for (int i = 0; i < nb; i++) begin
          e_b[i*W +: W]      = wr(lb[i], m_del[lb[i]]);
          e_b[(nb+i)*W +: W] = wf(lb[i], m_del[lb[i]]);
        end
      end
      nact = (mode == 2'd1) ? 2 : (mode == 2'd3) ? 0 : 4;
      for (int b = 0; b < 4; b++) actv[b] = (b < nact);
      if (mode != m_mode) begin
        m_mode = mode; m_lock = 0;
        for (int b = 0; b < 4; b++) begin s_at[b] = -1; m_del[b] = 0; end
      end else if (!m_lock && !m_err) begin
        allseen = (nact > 0);
        for (int b = 0; b < 4; b++) begin
          if (actv[b] && bus_stb[b] && s_at[b] < 0) s_at[b] = cyc;
          if (actv[b] && s_at[b] < 0) allseen = 0;
        end
        if (allseen) begin
          maxd = 0;
          for (int b = 0; b < 4; b++) if (actv[b] && cyc - s_at[b] > maxd) maxd = cyc - s_at[b];
          if (maxd > 3) m_err = 1;
          else begin
            m_lock = 1;
            for (int b = 0; b < 4; b++) m_del[b] = actv[b] ? cyc - s_at[b] : 0;
          end
        end
      end
      e_err = m_err;
      for (int b = 0; b < 4; b++) begin
        for (int k = 3; k > 1; k--) begin hr[b][k] = hr[b][k-1]; hf[b][k] = hf[b][k-1]; end
        hr[b][1] = bus_rise[b*W +: W]; hf[b][1] = bus_fall[b*W +: W];
      end
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      total++;
      if (out_valid !== e_v || cha_data !== e_a || chb_data !== e_b || align_err !== e_err) begin
        bad++;
        $display("FAIL %s: actual v=%b err=%b a=%h b=%h expected v=%b err=%b a=%h b=%h",
                 tag, out_valid, align_err, cha_data, chb_data, e_v, e_err, e_a, e_b);
      end
    end
  end

  task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] s);
    bus_rise = {$urandom, $urandom};
    bus_fall = {$urandom, $urandom};
    bus_stb = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(4'b0000);
  endtask

  task automatic restart(input logic [1:0] m);
    rst_n = 1'b0; mode = m;
    idle(3);
    check("R1 valid in reset", 64'(out_valid), 64'd0);
    check("R1 data in reset", 64'(|{cha_data, chb_data, align_err}), 64'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    tag = "R1"; restart(2'd0);
    tag = "R10"; idle(3);
    tag = "R2"; tick(4'b1111);
    check("R2 not yet valid", 64'(out_valid), 64'd0);
    tick(4'b0000);
    check("R2 valid one edge after lock", 64'(out_valid), 64'd1);
    tag = "R3"; idle(12);

    tag = "R6"; restart(2'd0);
    tick(4'b0001); tick(4'b0010); tick(4'b1000); tick(4'b0100);
    idle(12);
    check("R6 locked at skew 3", 64'(out_valid), 64'd1);

    tag = "R7"; restart(2'd2);
    tick(4'b0001); idle(3); tick(4'b1110);
    idle(6);
    check("R7 err set", 64'(align_err), 64'd1);
    check("R7 no valid", 64'(out_valid), 64'd0);
    tick(4'b1111); idle(3);
    check("R7 err sticky", 64'(align_err), 64'd1);

    tag = "R8"; restart(2'd2);
    tick(4'b0001); tick(4'b0010); tick(4'b1100);
    for (int i = 0; i < 20; i++) tick(4'($urandom));

    tag = "R5"; restart(2'd2);
    tick(4'b1111); idle(12);

    tag = "R4"; restart(2'd1);
    tick(4'b1100); tick(4'b0001); tick(4'b0010);
    idle(2);
    check("R9 lock without C/D", 64'(out_valid), 64'd1);
    tag = "R9";
    for (int i = 0; i < 12; i++) tick({2'($urandom), 2'b00});

    tag = "R11"; restart(2'd0);
    tick(4'b1111); idle(4);
    mode = 2'd2; tick(4'b1111);
    check("R11 valid dropped", 64'(out_valid), 64'd0);
    idle(4);
    check("R11 change-edge strobe ignored", 64'(out_valid), 64'd0);
    tick(4'b0011); tick(4'b1100); idle(10);
    check("R11 relocked", 64'(out_valid), 64'd1);

    tag = "R12"; restart(2'd3);
    tick(4'b1111); idle(8);
    check("R12 reserved never valid", 64'(out_valid), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule